// File: doc/BRIEF.md
# Pipeline Stall Interlock with Bubble Insertion

This block is the hazard control for an in-order, four-stage instruction pipeline whose stages run fetch, decode, execute and write-back. An instruction names a destination register and two source registers and carries an immediate. Its operands are read from a small register file while it sits in decode. Its result is the sum of both operands and the immediate, and it is written back in the write-back stage.

A read-after-write conflict arises when the instruction in decode needs a register that the instruction in execute will produce. The conflict is resolved only by waiting. Fetch and decode hold their contents for one cycle and an empty slot enters execute. One cycle later the producer has reached write-back. The register file passes a same-cycle write straight through to the decode read port, so the held instruction then picks up the correct value.

The per-stage valid bits, the decode source numbers, the execute destination and the write-back port are brought out so the timing can be watched from outside.

Top module: `pipe_interlock`

## Requirements
- R1: While reset is held, and in the first cycle after it, all four stage valid outputs, `stall`, `bubble` and `wb_we` are 0 and `in_ready` is 1.
- R2: `stall` and `bubble` are 1 in exactly those cycles where decode and execute both hold valid instructions, the execute destination is nonzero, and it equals at least one decode source number.
- R3: In a stall cycle `in_ready` is 0 and no input is accepted. In the next cycle decode still holds the same instruction (same source numbers, still valid) and fetch is unchanged.
- R4: The cycle after a stall has `e_valid` = 0, and the cycle after that has `w_valid` = 0.
- R5: A stall lasts exactly one cycle, so `stall` is never 1 in two consecutive cycles.
- R6: A register being written in write-back is read by decode in the same cycle with the new value, so a producer two instructions ahead causes no stall.
- R7: Register 0 reads as 0, is never written (`wb_we` stays 0 for destination 0) and never causes a stall.
- R8: Without hazards one instruction completes per cycle. Four back-to-back instructions occupy 7 cycles from the first fetch-valid cycle to the last write-back-valid cycle, and 8 cycles with one stall.
- R9: The value written back equals `R[rs1] + R[rs2] + imm`, modulo 2^DATA_W, using register values as seen in decode.
- R10: An empty slot (valid = 0) performs no register write: `wb_we` is 1 only when `w_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An instruction is offered to fetch |
| in_rd | input | REG_W | Destination register of the offered instruction |
| in_rs1 | input | REG_W | First source register |
| in_rs2 | input | REG_W | Second source register |
| in_imm | input | DATA_W | Immediate added to the operands |
| in_ready | output | 1 | Fetch accepts the offered instruction at the next edge |
| stall | output | 1 | Fetch and decode are frozen this cycle |
| bubble | output | 1 | An empty slot enters execute at the next edge |
| f_valid | output | 1 | Fetch stage holds an instruction |
| d_valid | output | 1 | Decode stage holds an instruction |
| d_rs1 | output | REG_W | First source number in decode |
| d_rs2 | output | REG_W | Second source number in decode |
| e_valid | output | 1 | Execute stage holds an instruction |
| e_rd | output | REG_W | Destination number in execute |
| w_valid | output | 1 | Write-back stage holds an instruction |
| wb_we | output | 1 | Register file write this cycle |
| wb_rd | output | REG_W | Register written back |
| wb_data | output | DATA_W | Value written back |

## Verification
The assertions check the local timing rules on every cycle. These are the freeze of decode and fetch after a stall, the empty execute and write-back slots that follow it, the absence of back-to-back stalls, the lack of stalls on register 0, and the rule that only valid slots write. The bench's reference model follows every instruction through the stages and checks the operand values it picks up, including the write-first case and the zero register. Only directed scenarios show the 7-versus-8 cycle spans, stall counts on dependency chains, and exact result values.

// File: rtl/pipe_pkg.sv
package pipe_pkg;

  localparam int unsigned PIPE_NUM_REGS = 16;
  localparam int unsigned PIPE_DATA_W   = 16;

  // A source depends on a producer when the producer writes a real register
  // (register 0 is constant) and the numbers match.
  function automatic logic reg_conflict(input int unsigned src, input int unsigned dst);
    return (dst != 0) && (src == dst);
  endfunction

endpackage

// File: rtl/pipe_hazard.sv
module pipe_hazard
  import pipe_pkg::*;
#(
  parameter int unsigned REG_W = 4
) (
  input  logic             dec_valid,
  input  logic [REG_W-1:0] dec_rs1,
  input  logic [REG_W-1:0] dec_rs2,
  input  logic             exe_valid,
  input  logic [REG_W-1:0] exe_rd,
  output logic             conflict
);

  logic hit_a;
  logic hit_b;

  always_comb begin
    hit_a    = reg_conflict(int'(dec_rs1), int'(exe_rd));
    hit_b    = reg_conflict(int'(dec_rs2), int'(exe_rd));
    conflict = dec_valid && exe_valid && (hit_a || hit_b);
  end

endmodule

// File: rtl/pipe_regfile.sv
module pipe_regfile #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned DATA_W   = 16,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NUM_REGS); i++) mem[i] <= '0;
    end else if (we && (waddr != '0)) begin
      mem[waddr] <= wdata;
    end
  end

  // Write-first: a same-cycle write is passed straight to the read port.
  logic pass_a;
  logic pass_b;

  assign pass_a  = we && (waddr == raddr_a);
  assign pass_b  = we && (waddr == raddr_b);
  assign rdata_a = (raddr_a == '0) ? '0 : (pass_a ? wdata : mem[raddr_a]);
  assign rdata_b = (raddr_b == '0) ? '0 : (pass_b ? wdata : mem[raddr_b]);

endmodule

// File: rtl/pipe_stage_reg.sv
module pipe_stage_reg #(
  parameter int unsigned PAYLOAD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hold,
  input  logic                 kill,
  input  logic                 d_valid,
  input  logic [PAYLOAD_W-1:0] d_data,
  output logic                 q_valid,
  output logic [PAYLOAD_W-1:0] q_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else if (!hold) begin
      q_valid <= d_valid && !kill;
      q_data  <= d_data;
    end
  end

endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pipe_pkg::*;
#(
  parameter int unsigned NUM_REGS = PIPE_NUM_REGS,
  parameter int unsigned DATA_W   = PIPE_DATA_W,
  localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [REG_W-1:0]  in_rd,
  input  logic [REG_W-1:0]  in_rs1,
  input  logic [REG_W-1:0]  in_rs2,
  input  logic [DATA_W-1:0] in_imm,
  output logic              in_ready,
  output logic              stall,
  output logic              bubble,
  output logic              f_valid,
  output logic              d_valid,
  output logic [REG_W-1:0]  d_rs1,
  output logic [REG_W-1:0]  d_rs2,
  output logic              e_valid,
  output logic [REG_W-1:0]  e_rd,
  output logic              w_valid,
  output logic              wb_we,
  output logic [REG_W-1:0]  wb_rd,
  output logic [DATA_W-1:0] wb_data
);

  localparam int unsigned FD_W = 3 * REG_W + DATA_W;
  localparam int unsigned EX_W = REG_W + 3 * DATA_W;
  localparam int unsigned WB_W = REG_W + DATA_W;

  function automatic logic [DATA_W-1:0] exec_sum(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b,
                                                 input logic [DATA_W-1:0] imm);
    return a + b + imm;
  endfunction

  // Named internal events
  logic              hazard;
  logic [FD_W-1:0]   f_data;
  logic [FD_W-1:0]   d_data;
  logic [EX_W-1:0]   e_data;
  logic [WB_W-1:0]   w_data;
  logic [REG_W-1:0]  d_rd;
  logic [DATA_W-1:0] d_imm;
  logic [DATA_W-1:0] opnd_a;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] e_a;
  logic [DATA_W-1:0] e_b;
  logic [DATA_W-1:0] e_imm;
  logic [DATA_W-1:0] e_sum;

  assign {d_rd, d_rs1, d_rs2, d_imm} = d_data;
  assign {e_rd, e_a, e_b, e_imm}     = e_data;
  assign {wb_rd, wb_data}            = w_data;
  assign e_sum                       = exec_sum(e_a, e_b, e_imm);

  pipe_hazard #(.REG_W(REG_W)) u_hazard (
    .dec_valid (d_valid),
    .dec_rs1   (d_rs1),
    .dec_rs2   (d_rs2),
    .exe_valid (e_valid),
    .exe_rd    (e_rd),
    .conflict  (hazard)
  );

  assign stall    = hazard;
  assign bubble   = hazard;
  assign in_ready = !hazard;
  assign wb_we    = w_valid && (wb_rd != '0);

  pipe_stage_reg #(.PAYLOAD_W(FD_W)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hazard),
    .kill    (1'b0),
    .d_valid (in_valid),
    .d_data  ({in_rd, in_rs1, in_rs2, in_imm}),
    .q_valid (f_valid),
    .q_data  (f_data)
  );

  pipe_stage_reg #(.PAYLOAD_W(FD_W)) u_decode (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hazard),
    .kill    (1'b0),
    .d_valid (f_valid),
    .d_data  (f_data),
    .q_valid (d_valid),
    .q_data  (d_data)
  );

  pipe_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wb_we),
    .waddr   (wb_rd),
    .wdata   (wb_data),
    .raddr_a (d_rs1),
    .raddr_b (d_rs2),
    .rdata_a (opnd_a),
    .rdata_b (opnd_b)
  );

  pipe_stage_reg #(.PAYLOAD_W(EX_W)) u_execute (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (1'b0),
    .kill    (hazard),
    .d_valid (d_valid),
    .d_data  ({d_rd, opnd_a, opnd_b, d_imm}),
    .q_valid (e_valid),
    .q_data  (e_data)
  );

  pipe_stage_reg #(.PAYLOAD_W(WB_W)) u_writeback (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (1'b0),
    .kill    (1'b0),
    .d_valid (e_valid),
    .d_data  ({e_rd, e_sum}),
    .q_valid (w_valid),
    .q_data  (w_data)
  );

endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk #(
  parameter int unsigned REG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             stall,
  input logic             f_valid,
  input logic             d_valid,
  input logic [REG_W-1:0] d_rs1,
  input logic [REG_W-1:0] d_rs2,
  input logic             e_valid,
  input logic [REG_W-1:0] e_rd,
  input logic             w_valid,
  input logic             wb_we,
  input logic [REG_W-1:0] wb_rd
);

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !in_ready) else $error("input accepted during stall"); // R3

  AST_DECODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> d_valid && $stable(d_rs1) && $stable(d_rs2)) else $error("decode not held"); // R3

  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(f_valid)) else $error("fetch not held"); // R3

  AST_EXEC_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !e_valid) else $error("execute not idle after stall"); // R4

  AST_WB_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ##1 !w_valid) else $error("write-back not idle two cycles after stall"); // R4

  AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall) else $error("stall lasted more than one cycle"); // R5

  AST_ZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (e_rd == '0) |-> !stall) else $error("register 0 caused a stall"); // R7

  AST_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> (wb_rd != '0)) else $error("write to register 0"); // R7

  AST_BUBBLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> w_valid) else $error("empty slot wrote a register"); // R10

endmodule

bind pipe_interlock pipe_interlock_chk #(.REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .stall    (stall),
  .f_valid  (f_valid),
  .d_valid  (d_valid),
  .d_rs1    (d_rs1),
  .d_rs2    (d_rs2),
  .e_valid  (e_valid),
  .e_rd     (e_rd),
  .w_valid  (w_valid),
  .wb_we    (wb_we),
  .wb_rd    (wb_rd)
);

// File: tb/pipe_interlock_tb.sv
module pipe_interlock_tb;

  localparam int NREG = 16;
  localparam int RW   = 4;
  localparam int DW   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [RW-1:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [DW-1:0] in_imm = '0;
  logic          in_ready, stall, bubble, f_valid, d_valid, e_valid, w_valid, wb_we;
  logic [RW-1:0] d_rs1, d_rs2, e_rd, wb_rd;
  logic [DW-1:0] wb_data;

  always #10 clk = ~clk;

  pipe_interlock u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rd(in_rd), .in_rs1(in_rs1),
    .in_rs2(in_rs2), .in_imm(in_imm), .in_ready(in_ready), .stall(stall), .bubble(bubble),
    .f_valid(f_valid), .d_valid(d_valid), .d_rs1(d_rs1), .d_rs2(d_rs2), .e_valid(e_valid),
    .e_rd(e_rd), .w_valid(w_valid), .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Behavioural reference: slot 0=fetch 1=decode 2=execute 3=write-back
  int          mv[4], mrd[4], ms1[4], ms2[4];
  logic [DW-1:0] mimm[4], ma[4], mb[4], mres[4];
  logic [DW-1:0] regs[NREG];

  function automatic bit m_stall();
    return mv[1] != 0 && mv[2] != 0 && mrd[2] != 0 && (mrd[2] == ms1[1] || mrd[2] == ms2[1]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        mv[i] = 0; mrd[i] = 0; ms1[i] = 0; ms2[i] = 0;
        mimm[i] = '0; ma[i] = '0; mb[i] = '0; mres[i] = '0;
      end
      for (int r = 0; r < NREG; r++) regs[r] = '0;
    end else begin
      bit st;
      st = m_stall();
      if (mv[3] != 0 && mrd[3] != 0) regs[mrd[3]] = mres[3];
      mv[3] = mv[2]; mrd[3] = mrd[2]; mres[3] = ma[2] + mb[2] + mimm[2];
      if (st) mv[2] = 0;
      else begin
        mv[2] = mv[1]; mrd[2] = mrd[1]; mimm[2] = mimm[1];
        ma[2] = regs[ms1[1]]; mb[2] = regs[ms2[1]];
        mv[1] = mv[0]; mrd[1] = mrd[0]; ms1[1] = ms1[0]; ms2[1] = ms2[0]; mimm[1] = mimm[0];
        mv[0] = int'(in_valid); mrd[0] = int'(in_rd); ms1[0] = int'(in_rs1);
        ms2[0] = int'(in_rs2); mimm[0] = in_imm;
      end
    end
  end

  // Scenario bookkeeping from observed ports
  int cyc = 0, first_f = -1, last_w = -1, stall_cnt = 0, wb0_cnt = 0;
  logic [DW-1:0] last_wb[NREG];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check("R4", "f_valid", int'(f_valid), mv[0]);
      check("R4", "d_valid", int'(d_valid), mv[1]);
      check("R4", "e_valid", int'(e_valid), mv[2]);
      check("R4", "w_valid", int'(w_valid), mv[3]);
      check("R2", "stall", int'(stall), int'(m_stall()));
      check("R2", "bubble", int'(bubble), int'(m_stall()));
      check("R3", "in_ready", int'(in_ready), int'(!m_stall()));
      if (mv[1] != 0) begin
        check("R3", "d_rs1", int'(d_rs1), ms1[1]);
        check("R3", "d_rs2", int'(d_rs2), ms2[1]);
      end
      if (mv[2] != 0) check("R2", "e_rd", int'(e_rd), mrd[2]);
      check("R10", "wb_we", int'(wb_we), int'(mv[3] != 0 && mrd[3] != 0));
      if (mv[3] != 0 && mrd[3] != 0) begin
        check("R9", "wb_rd", int'(wb_rd), mrd[3]);
        check("R9", "wb_data", int'(wb_data), int'(mres[3]));
      end
      if (f_valid && first_f < 0) first_f = cyc;
      if (w_valid) last_w = cyc;
      if (stall) stall_cnt++;
      if (w_valid && wb_rd == '0) wb0_cnt++;
      if (wb_we) last_wb[wb_rd] = wb_data;
    end
  end

  task automatic mark();
    first_f = -1; last_w = -1; stall_cnt = 0; wb0_cnt = 0;
  endtask

  task automatic issue(input int rd, input int rs1, input int rs2, input int imm);
    bit acc;
    in_valid = 1'b1;
    in_rd = RW'(rd); in_rs1 = RW'(rs1); in_rs2 = RW'(rs2); in_imm = DW'(imm);
    do begin
      acc = !m_stall();
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] seed;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: state under reset
    check("R1", "f_valid in reset", int'(f_valid), 0);
    check("R1", "w_valid in reset", int'(w_valid), 0);
    check("R1", "stall in reset", int'(stall), 0);
    check("R1", "wb_we in reset", int'(wb_we), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "d_valid after reset", int'(d_valid), 0);
    check("R1", "e_valid after reset", int'(e_valid), 0);
    check("R1", "in_ready after reset", int'(in_ready), 1);

    // R8: four independent instructions, no stall -> 7 cycles
    mark();
    issue(1, 5, 6, 10); issue(2, 5, 6, 20); issue(3, 5, 6, 30); issue(4, 5, 6, 40);
    idle(8);
    check("R8", "span without hazard", last_w - first_f + 1, 7);
    check("R8", "stalls without hazard", stall_cnt, 0);

    // R5/R8: one dependency on execute -> one stall, 8 cycles
    mark();
    issue(7, 0, 0, 5); issue(8, 7, 0, 1); issue(9, 1, 2, 0); issue(10, 0, 0, 3);
    idle(8);
    check("R8", "span with one stall", last_w - first_f + 1, 8);
    check("R5", "single stall count", stall_cnt, 1);
    check("R9", "dependent result r8", int'(last_wb[8]), 6);
    check("R9", "independent result r9", int'(last_wb[9]), 30);

    // R7: register 0 as destination and source
    mark();
    issue(0, 0, 0, 99); issue(11, 0, 0, 2);
    idle(6);
    check("R7", "stalls on r0", stall_cnt, 0);
    check("R7", "r0 reads zero", int'(last_wb[11]), 2);
    check("R7", "no write to r0", int'(last_wb[0]), 0);

    // R6: producer two ahead resolved by write-first read
    mark();
    issue(3, 0, 0, 40); issue(4, 0, 0, 1); issue(5, 3, 3, 2);
    idle(6);
    check("R6", "stalls at distance two", stall_cnt, 0);
    check("R6", "write-first operand", int'(last_wb[5]), 82);

    // R5: chain, each link stalls once, with both sources matching
    mark();
    issue(12, 0, 0, 3); issue(12, 12, 12, 0); issue(13, 12, 0, 1);
    idle(8);
    check("R5", "chain stall count", stall_cnt, 2);
    check("R9", "chain result r12", int'(last_wb[12]), 6);
    check("R9", "chain result r13", int'(last_wb[13]), 7);

    // R2/R9: pseudo-random stream with gaps, compared by the model each cycle
    seed = 32'h1234_5678;
    for (int k = 0; k < 300; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      if (seed[30:29] == 2'b00) idle(1);
      else issue(int'(seed[27:24]), int'(seed[22:20]), int'(seed[18:16]), int'(seed[15:8]));
    end
    idle(8);
    finish_run();
  end

endmodule